// File: doc/BRIEF.md
# Dual 16-bit saturating add/subtract unit

This ALU slice treats its two 32-bit operands either as pairs of signed 16-bit halves or as single 32-bit words. In pair mode each half is added or subtracted on its own, with the operation picked separately for the upper and the lower half. Optional saturation clamps each half to the signed 16-bit range. An optional cross setting exchanges the two half results before they are written. Word mode performs one 32-bit add or subtract, with optional saturation to the signed 32-bit range. Half mode takes either half of each operand, computes one 16-bit result and writes it only to the destination halves enabled by the half-write mask.

The result lands in a destination register on the rising clock edge while the write enable is high. Each half of that register is written only when its mask bit is set. Status flags and accumulators are not part of this block.

Top module: `pk_alu16x2`

## Requirements
- R1: After the active-low asynchronous reset, dst_o reads 0x00000000.
- R2: With mode_i = 0 (pair), the upper result half is op_a[31:16] minus op_b[31:16] when hi_sub_i = 1 and their sum otherwise. The lower half does the same on bits [15:0] under lo_sub_i. All four combinations are legal.
- R3: With sat_i = 1, a 16-bit result that overflows positively becomes 0x7FFF and one that overflows negatively becomes 0x8000. This applies in pair mode and in half mode.
- R4: With sat_i = 0, each 16-bit result wraps modulo 2^16.
- R5: With mode_i = 0 and cross_i = 1, the lower-half result goes to dst bits [31:16] and the upper-half result goes to bits [15:0].
- R6: With mode_i = 1 (word), the result is op_a + op_b, or op_a - op_b when lo_sub_i = 1, over 32 bits. With sat_i = 1 an overflow clamps to 0x7FFFFFFF or 0x80000000; without saturation the result wraps.
- R7: With mode_i = 2 (half), the first source is op_a[31:16] when src_a_hi_i = 1 and op_a[15:0] otherwise; the second source is picked from op_b the same way by src_b_hi_i. The 16-bit result goes to every destination half whose mask bit is set (wmask_i[1] for bits [31:16], wmask_i[0] for bits [15:0]). A half whose mask bit is clear keeps its value, in every mode.
- R8: While wr_en_i = 0, dst_o holds its value.
- R9: mode_i = 3 is reserved and leaves dst_o unchanged even with wr_en_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Destination write enable |
| mode_i | input | 2 | 0 pair, 1 word, 2 half, 3 reserved |
| hi_sub_i | input | 1 | Subtract on the upper lane (pair mode) |
| lo_sub_i | input | 1 | Subtract on the lower lane, word and half operations |
| sat_i | input | 1 | Saturate the result |
| cross_i | input | 1 | Swap the two half results (pair mode) |
| src_a_hi_i | input | 1 | Half mode: take the upper half of op_a |
| src_b_hi_i | input | 1 | Half mode: take the upper half of op_b |
| wmask_i | input | 2 | Half-write mask: bit 1 upper, bit 0 lower |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| dst_o | output | 32 | Destination register |

## Verification
Pair mode is driven with all four add/subtract combinations, with and without saturation and cross. One operand pair makes the upper lane overflow positively and the lower lane overflow negatively at the same time. That separates a clamp toward 0x7FFF from a clamp toward 0x8000, and it shows whether cross swaps the clamped values. Word mode is tried at both overflow ends with and without saturation, so 32-bit clamping is told apart from a per-lane clamp. Half mode walks every source-half choice under single-bit masks, which shows that the untouched half keeps the value written earlier.

// File: rtl/pk_alu_pkg.sv
package pk_alu_pkg;
  typedef enum logic [1:0] {
    MODE_PAIR = 2'd0,
    MODE_WORD = 2'd1,
    MODE_HALF = 2'd2,
    MODE_RSVD = 2'd3
  } alu_mode_e;
endpackage

// File: rtl/pk_addsub_sat.sv
module pk_addsub_sat #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         sat_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         ovf;

  // subtract as a + ~b + 1
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  assign ovf   = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);

  always_comb begin
    if (sat_i && ovf) res_o = a_i[W-1] ? MAX_NEG : MAX_POS;
    else              res_o = sum;
  end

  // R3: a saturated result never has a sign opposite to two like-signed inputs
  always_comb begin
    if (sat_i && (a_i[W-1] == b_eff[W-1]))
      a_r3_sat_sign: assert (res_o[W-1] == a_i[W-1]);
  end
endmodule

// File: rtl/pk_dst_reg.sv
module pk_dst_reg #(
  parameter int HW    = 16,
  parameter int NHALF = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NHALF-1:0]    wmask_i,
  input  logic [NHALF*HW-1:0] d_i,
  output logic [NHALF*HW-1:0] q_o
);
  for (genvar g = 0; g < NHALF; g++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      q_o[g*HW +: HW] <= '0;
      else if (wr_en_i && wmask_i[g])   q_o[g*HW +: HW] <= d_i[g*HW +: HW];
    end

    // R7: a half whose mask bit is clear keeps its value
    a_r7_keep_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wmask_i[g] |=> $stable(q_o[g*HW +: HW]));
  end

  // R8: nothing changes while the write enable is low
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_o));
endmodule

// File: rtl/pk_alu16x2.sv
module pk_alu16x2
  import pk_alu_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    mode_i,
  input  logic          hi_sub_i,
  input  logic          lo_sub_i,
  input  logic          sat_i,
  input  logic          cross_i,
  input  logic          src_a_hi_i,
  input  logic          src_b_hi_i,
  input  logic [1:0]    wmask_i,
  input  logic [2*HW-1:0] op_a_i,
  input  logic [2*HW-1:0] op_b_i,
  output logic [2*HW-1:0] dst_o
);
  localparam int DW = 2 * HW;

  alu_mode_e   mode;
  logic [HW-1:0] lane_res [2];
  logic [HW-1:0] half_a, half_b, half_res;
  logic [DW-1:0] word_res;
  logic [DW-1:0] pair_res;
  logic [DW-1:0] next_d;
  logic          wr_ok;

  assign mode = alu_mode_e'(mode_i);

  // lane 0 = lower, lane 1 = upper
  for (genvar l = 0; l < 2; l++) begin : g_lane
    pk_addsub_sat #(.W(HW)) u_lane (
      .a_i  (op_a_i[l*HW +: HW]),
      .b_i  (op_b_i[l*HW +: HW]),
      .sub_i((l == 1) ? hi_sub_i : lo_sub_i),
      .sat_i(sat_i),
      .res_o(lane_res[l])
    );
  end

  assign pair_res = cross_i ? {lane_res[0], lane_res[1]} : {lane_res[1], lane_res[0]};

  pk_addsub_sat #(.W(DW)) u_word (
    .a_i  (op_a_i),
    .b_i  (op_b_i),
    .sub_i(lo_sub_i),
    .sat_i(sat_i),
    .res_o(word_res)
  );

  assign half_a = src_a_hi_i ? op_a_i[DW-1:HW] : op_a_i[HW-1:0];
  assign half_b = src_b_hi_i ? op_b_i[DW-1:HW] : op_b_i[HW-1:0];

  pk_addsub_sat #(.W(HW)) u_half (
    .a_i  (half_a),
    .b_i  (half_b),
    .sub_i(lo_sub_i),
    .sat_i(sat_i),
    .res_o(half_res)
  );

  always_comb begin
    next_d = pair_res;
    wr_ok  = wr_en_i;
    unique case (mode)
      MODE_PAIR: next_d = pair_res;
      MODE_WORD: next_d = word_res;
      MODE_HALF: next_d = {half_res, half_res};
      MODE_RSVD: wr_ok  = 1'b0;
    endcase
  end

  pk_dst_reg #(.HW(HW), .NHALF(2)) u_dst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_ok),
    .wmask_i(wmask_i),
    .d_i    (next_d),
    .q_o    (dst_o)
  );

  // R9: the reserved mode never writes
  a_r9_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> $stable(dst_o));

  // R5: in pair mode with cross, the two halves of the written value are exchanged
  a_r5_cross_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_i == 2'd0 && cross_i && wmask_i == 2'b11)
      |=> (dst_o == {$past(lane_res[0]), $past(lane_res[1])}));
endmodule

// File: tb/pk_alu16x2_bench.sv
module pk_alu16x2_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        hs = 1'b0, ls = 1'b0, sat = 1'b0, crs = 1'b0, sah = 1'b0, sbh = 1'b0;
  logic [1:0]  wm = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic [31:0] dst;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pk_alu16x2 u_pk_alu16x2 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .mode_i(mode),
    .hi_sub_i(hs), .lo_sub_i(ls), .sat_i(sat), .cross_i(crs),
    .src_a_hi_i(sah), .src_b_hi_i(sbh), .wmask_i(wm),
    .op_a_i(a), .op_b_i(b), .dst_o(dst)
  );

  // {req, mode, hs, ls, sat, cross, sah, sbh, wmask, a, b, expected}
  localparam int NV = 21;
  localparam logic [109:0] VEC [NV] = '{
    {4'd3, 2'd0, 6'b001000, 2'b11, 32'h456789AB, 32'h6789ABCD, 32'h7FFF8000},
    {4'd5, 2'd0, 6'b001100, 2'b11, 32'h456789AB, 32'h6789ABCD, 32'h80007FFF},
    {4'd2, 2'd0, 6'b011000, 2'b11, 32'h456789AB, 32'h6789ABCD, 32'h7FFFDDDE},
    {4'd5, 2'd0, 6'b101100, 2'b11, 32'h456789AB, 32'h6789ABCD, 32'h8000DDDE},
    {4'd2, 2'd0, 6'b110000, 2'b11, 32'h456789AB, 32'h6789ABCD, 32'hDDDEDDDE},
    {4'd4, 2'd0, 6'b000000, 2'b11, 32'h456789AB, 32'h6789ABCD, 32'hACF03578},
    {4'd5, 2'd0, 6'b010100, 2'b11, 32'h456789AB, 32'h6789ABCD, 32'hDDDEACF0},
    {4'd6, 2'd1, 6'b000000, 2'b11, 32'h6789ABCD, 32'h456789AB, 32'hACF13578},
    {4'd6, 2'd1, 6'b001000, 2'b11, 32'h6789ABCD, 32'h456789AB, 32'h7FFFFFFF},
    {4'd6, 2'd1, 6'b010000, 2'b11, 32'h6789ABCD, 32'h456789AB, 32'h22222222},
    {4'd6, 2'd1, 6'b011000, 2'b11, 32'h80000000, 32'h00000001, 32'h80000000},
    {4'd6, 2'd1, 6'b010000, 2'b11, 32'h80000000, 32'h00000001, 32'h7FFFFFFF},
    {4'd7, 2'd2, 6'b000000, 2'b01, 32'h6789ABCD, 32'h456789AB, 32'h7FFF3578},
    {4'd7, 2'd2, 6'b000001, 2'b10, 32'h6789ABCD, 32'h456789AB, 32'hF1343578},
    {4'd3, 2'd2, 6'b001011, 2'b10, 32'h6789ABCD, 32'h456789AB, 32'h7FFF3578},
    {4'd3, 2'd2, 6'b001000, 2'b10, 32'h6789ABCD, 32'h456789AB, 32'h80003578},
    {4'd7, 2'd2, 6'b001010, 2'b01, 32'h6789ABCD, 32'h456789AB, 32'h8000F134},
    {4'd3, 2'd2, 6'b011000, 2'b01, 32'h00008000, 32'h00000001, 32'h80008000},
    {4'd4, 2'd2, 6'b010000, 2'b01, 32'h00008000, 32'h00000001, 32'h80007FFF},
    {4'd7, 2'd0, 6'b000000, 2'b00, 32'h11111111, 32'h22222222, 32'h80007FFF},
    {4'd3, 2'd0, 6'b111000, 2'b11, 32'h7FFF7FFF, 32'hFFFF8000, 32'h7FFF7FFF}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (dst !== exp) begin
      errors++;
      $display("FAIL %s: dst=%08h expected=%08h", req, dst, exp);
    end
  endtask

  // inputs at negedge, capture at posedge, sample at following negedge
  task automatic step(input logic we, input logic [1:0] md, input logic [5:0] f,
                      input logic [1:0] m, input logic [31:0] va, input logic [31:0] vb);
    @(negedge clk);
    wr_en = we; mode = md;
    {hs, ls, sat, crs, sah, sbh} = f;
    wm = m; a = va; b = vb;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'h0000_0000);   // R1 reset value
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h0000_0000);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][105:104], VEC[i][103:98], VEC[i][97:96],
           VEC[i][95:64], VEC[i][63:32]);
      check(req_name(VEC[i][109:106]), VEC[i][31:0]);
    end

    // R8: write enable low holds the value
    step(1'b0, 2'd1, 6'b000000, 2'b11, 32'h00000001, 32'h00000001);
    check("R8", 32'h7FFF7FFF);
    // R9: reserved mode does not write
    step(1'b1, 2'd3, 6'b000000, 2'b11, 32'h00000001, 32'h00000001);
    check("R9", 32'h7FFF7FFF);
    // R7: cross result under a lower-only mask writes only the swapped lower half
    step(1'b1, 2'd0, 6'b000100, 2'b01, 32'h00010002, 32'h00100020);
    check("R7", 32'h7FFF0011);
    // R1: reset mid-run clears the register
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 32'h0000_0000);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule